// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-port synchronous memory for a burst sequencer. The sequencer presents a word address, a select and the write controls each clock. The block captures all of them, together with the write data, in input registers on the rising edge. The array is updated from those registers on the following edge, with no further handshake. A read is pipelined through one output register, so the word is available one clock after its address is captured.

Writes work on eight 8-bit lanes. A byte-write master enable qualifies the per-lane enables. A separate global-write control overrides both and writes the whole word. The output side reports read data with a valid flag that stands in for the enabled or high-impedance state of a pad. The flag is cleared for deselected or write cycles, and it is masked at once by the active-low output enable. The chip instance sets the address width to 16, which gives 65,536 words. The default of 8 keeps the elaborated array small.

Top module: `sram_pipe_bw`

## Requirements
- R1: The array holds 2**ADDR_W words of 64 bits (ADDR_W = 16 in the chip instance). A word written at any address is read back unchanged.
- R2: With gw_ni = 1 and bwe_ni = 0, lane n (data bits 8n+7 down to 8n, n = 0..7) is written only where bw_ni[n] = 0. Lanes with bw_ni[n] = 1 keep their old value.
- R3: gw_ni = 0 with sel_i = 1 writes all eight lanes, whatever the values of bwe_ni and bw_ni.
- R4: A selected cycle with no lane enabled is a read and changes no lane. That is the case when gw_ni = 1 and bwe_ni = 1 (even with bw_ni low), or when gw_ni = 1, bwe_ni = 0 and bw_ni = 8'hFF.
- R5: Inputs are captured on the rising edge. For a read captured on edge k, rvalid_o = 1 and rdata_o holds the word after edge k+1. Unless another read is captured on edge k+1, rvalid_o returns to 0 after edge k+2.
- R6: A cycle with sel_i = 0 writes nothing, even with gw_ni = 0, and gives rvalid_o = 0 one clock after capture.
- R7: oe_ni = 1 forces rvalid_o = 0 and rdata_o = 0 without waiting for a clock. Returning oe_ni to 0 shows the held read word again.
- R8: A read captured on the edge right after a write to the same address returns the newly written lanes merged with the unwritten old lanes.
- R9: While rst_ni = 0, rvalid_o = 0 and rdata_o = 0.
- R10: A write cycle gives rvalid_o = 0 one clock after capture, and rdata_o = 0 whenever rvalid_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access select, active high |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 64 | Write data |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write master enable, active low |
| bw_ni | input | 8 | Per-lane write enables, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | 64 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid (low models high impedance) |

## Verification
On every cycle, the assertions check how the write controls decode into the captured operation: the global override, the read case with lanes held off, and the per-lane mask. They also check the one-clock spacing between a captured read and the valid flag, that write and deselected cycles leave the flag low, and that output enable masks the output. Only the bench scenarios can show the stored contents. That covers which lanes actually change, that nothing changes on a read or a deselected cycle, and the merged word read right after a partial write. It also covers that the held word comes back when output enable is cleared again.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  parameter int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_wr_decode.sv
`timescale 1ns/1ps
module sram_wr_decode
  import sram_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             sel_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output op_e              op_o,
  output logic [LANES-1:0] lane_we_o
);
  logic [LANES-1:0] lane_req;

  always_comb begin
    if (!gw_ni)       lane_req = '1;        // global override
    else if (!bwe_ni) lane_req = ~bw_ni;
    else              lane_req = '0;
  end

  always_comb begin
    if (!sel_i) begin
      op_o      = OP_IDLE;
      lane_we_o = '0;
    end else begin
      op_o      = (|lane_req) ? OP_WRITE : OP_READ;
      lane_we_o = lane_req;
    end
  end
endmodule

// File: rtl/sram_bank.sv
`timescale 1ns/1ps
module sram_bank
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i)    rd_q        <= mem[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_out_stage.sv
`timescale 1ns/1ps
module sram_out_stage #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_issue_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] rdata_raw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic rd_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_issue_i;
  end

  // selection through the pipe, output enable straight through
  assign rvalid_o = rd_vld_q & ~oe_ni;
  assign rdata_o  = rvalid_o ? rdata_raw_i : '0;

  AST_NO_DATA_WHEN_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0)); // R10
endmodule

// File: rtl/sram_pipe_bw.sv
`timescale 1ns/1ps
module sram_pipe_bw
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  op_e              op_d, op_q;
  logic [LANES-1:0] lane_we_d, lane_we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] bank_rdata;
  logic              rd_issue;

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .sel_i     (sel_i),
    .gw_ni     (gw_ni),
    .bwe_ni    (bwe_ni),
    .bw_ni     (bw_ni),
    .op_o      (op_d),
    .lane_we_o (lane_we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      lane_we_q <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      op_q      <= op_d;
      lane_we_q <= lane_we_d;
      addr_q    <= addr_i;
      wdata_q   <= wdata_i;
    end
  end

  assign rd_issue = (op_q == OP_READ);

  sram_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank (
    .clk_i   (clk_i),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .we_i    (lane_we_q),
    .re_i    (rd_issue),
    .rdata_o (bank_rdata)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_issue_i  (rd_issue),
    .oe_ni       (oe_ni),
    .rdata_raw_i (bank_rdata),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

  AST_LANE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && gw_ni && !bwe_ni) |=> (lane_we_q == ~$past(bw_ni))); // R2
  AST_GLOBAL_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !gw_ni) |=> (op_q == OP_WRITE && (&lane_we_q))); // R3
  AST_READ_NO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && gw_ni && bwe_ni) |=> (op_q == OP_READ && lane_we_q == '0)); // R4
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_READ) |=> (rvalid_o || oe_ni)); // R5
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (lane_we_q == '0) ##1 !rvalid_o); // R6
  AST_OE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rvalid_o); // R7
  AST_WRITE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_WRITE) |=> !rvalid_o); // R10
endmodule

// File: tb/sram_pipe_bw_bench.sv
`timescale 1ns/1ps
module sram_pipe_bw_bench;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic          gw_n = 1'b1;
  logic          bwe_n = 1'b1;
  logic [7:0]    bw_n = 8'hFF;
  logic          oe_n = 1'b0;
  logic [63:0]   rdata;
  logic          rvalid;

  logic [63:0] ref_mem [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_pipe_bw #(.ADDR_W(AW)) u_sram_pipe_bw (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr), .wdata_i(wdata),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [AW-1:0] a, input logic [63:0] d,
                       input logic g, input logic be, input logic [7:0] b);
    sel = s; addr = a; wdata = d; gw_n = g; bwe_n = be; bw_n = b;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, 1'b1, 1'b1, 8'hFF);
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [63:0] d);
    drive(1'b1, a, d, 1'b0, 1'b1, 8'hFF);
    ref_mem[a] = d;
  endtask

  task automatic wr_lanes(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] b);
    drive(1'b1, a, d, 1'b1, 1'b0, b);
    for (int n = 0; n < 8; n++)
      if (!b[n]) ref_mem[a][n*8 +: 8] = d[n*8 +: 8];
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a);
    drive(1'b1, a, 64'hDEAD_BEEF_0BAD_F00D, 1'b1, 1'b1, 8'h00);
    idle();
    chk(req, {63'd0, rvalid}, 64'd1);
    chk(req, rdata, ref_mem[a]);
  endtask

  task automatic t_reset();
    chk("R9 rvalid", {63'd0, rvalid}, 64'd0);
    chk("R9 rdata", rdata, 64'd0);
  endtask

  task automatic t_full_rw();
    wr_full(8'h00, 64'h0123_4567_89AB_CDEF);
    wr_full(8'hFF, 64'hFFFF_0000_FFFF_0000);
    wr_full(8'h5A, 64'hA5A5_5A5A_C3C3_3C3C);
    idle();
    rd_check("R1 addr0", 8'h00);
    rd_check("R1 addrmax", 8'hFF);
    rd_check("R1 addr5a", 8'h5A);
  endtask

  task automatic t_lanes();
    wr_full(8'h10, 64'h0);
    for (int n = 0; n < 8; n++) begin
      logic [7:0] m;
      m = ~(8'h01 << n);
      wr_lanes(8'h10, {8{8'h11 * (n + 1)}}, m);
    end
    idle();
    rd_check("R2 single lanes", 8'h10);
    wr_lanes(8'h10, 64'hFFFF_FFFF_FFFF_FFFF, 8'b1010_0101);
    idle();
    rd_check("R2 mixed lanes", 8'h10);
  endtask

  task automatic t_global();
    wr_full(8'h20, 64'h1111_2222_3333_4444);
    drive(1'b1, 8'h20, 64'h9999_8888_7777_6666, 1'b0, 1'b1, 8'hFF);
    ref_mem[8'h20] = 64'h9999_8888_7777_6666;
    drive(1'b1, 8'h20, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 1'b0, 8'hAA);
    ref_mem[8'h20] = 64'h0F0F_0F0F_0F0F_0F0F;
    idle();
    rd_check("R3 global write", 8'h20);
  endtask

  task automatic t_read_only();
    wr_full(8'h30, 64'hCAFE_BABE_1234_5678);
    drive(1'b1, 8'h30, 64'h0, 1'b1, 1'b1, 8'h00);
    idle();
    chk("R4 bwe high read valid", {63'd0, rvalid}, 64'd1);
    chk("R4 bwe high read data", rdata, 64'hCAFE_BABE_1234_5678);
    drive(1'b1, 8'h30, 64'h0, 1'b1, 1'b0, 8'hFF);
    idle();
    chk("R4 no lane read valid", {63'd0, rvalid}, 64'd1);
    rd_check("R4 unchanged", 8'h30);
  endtask

  task automatic t_latency();
    wr_full(8'h40, 64'h4040_4040_4040_4040);
    idle();
    drive(1'b1, 8'h40, 64'h0, 1'b1, 1'b1, 8'hFF);
    chk("R5 not yet valid", {63'd0, rvalid}, 64'd0);
    idle();
    chk("R5 valid after one clock", {63'd0, rvalid}, 64'd1);
    chk("R5 data", rdata, 64'h4040_4040_4040_4040);
    idle();
    chk("R5 valid drops", {63'd0, rvalid}, 64'd0);
  endtask

  task automatic t_desel();
    wr_full(8'h50, 64'h5050_5050_5050_5050);
    drive(1'b0, 8'h50, 64'h0, 1'b0, 1'b0, 8'h00);
    idle();
    chk("R6 deselected invalid", {63'd0, rvalid}, 64'd0);
    rd_check("R6 no write when deselected", 8'h50);
  endtask

  task automatic t_oe();
    wr_full(8'h60, 64'h6666_7777_8888_9999);
    drive(1'b1, 8'h60, 64'h0, 1'b1, 1'b1, 8'hFF);
    idle();
    oe_n = 1'b1;
    #1;
    chk("R7 oe masks valid", {63'd0, rvalid}, 64'd0);
    chk("R7 oe masks data", rdata, 64'd0);
    oe_n = 1'b0;
    #1;
    chk("R7 data returns", rdata, 64'h6666_7777_8888_9999);
  endtask

  task automatic t_merge();
    wr_full(8'h70, 64'hAAAA_AAAA_AAAA_AAAA);
    wr_lanes(8'h70, 64'h1122_3344_5566_7788, 8'b1100_0011);
    rd_check("R8 merged back-to-back", 8'h70);
    chk("R8 merged value", ref_mem[8'h70], 64'hAAAA_3344_5566_AAAA);
  endtask

  task automatic t_wr_invalid();
    wr_full(8'h80, 64'h8080_8080_8080_8080);
    idle();
    chk("R10 write gives invalid", {63'd0, rvalid}, 64'd0);
    chk("R10 invalid data zero", rdata, 64'd0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_rw();
    t_lanes();
    t_global();
    t_read_only();
    t_latency();
    t_desel();
    t_oe();
    t_merge();
    t_wr_invalid();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule